// File: doc/BRIEF.md
# Burst Column Address Generator

This block is the column counter inside a synchronous DRAM device. A read or write command supplies a start column. The block then produces the column address of every beat of the burst, one address per clock. The burst shape comes from a length code and an order bit. The block captures both when the command arrives, so later changes to the mode inputs do not disturb a running burst.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside the aligned block of their own size. The order is either sequential (the low bits count upward) or interleaved (the low bits of the start column are XORed with a beat counter). A full-page burst counts through the whole column range and wraps at the top. It ends only when a stop or a terminate command arrives. A new command always restarts the burst with the full programmed length at the new column, so issuing a command on every clock gives random column access. Storage, data path, refresh and latency delay belong to other blocks.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `burst_act` is 0 and `col_out` is 0.
- R2: When `cmd_new` is sampled high at a rising edge, `col_out` equals `start_col` and `burst_act` is 1 after that edge. The length and order in force are those on `len_code` and `ilv_mode` at that edge.
- R3: Length codes are 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8. With `ilv_mode` = 0, beat k of a fixed burst of N beats from start s is (s & ~(N-1)) | ((s + k) & (N-1)).
- R4: With `ilv_mode` = 1, beat k of a fixed burst of N beats is (s & ~(N-1)) | ((s ^ k) & (N-1)).
- R5: A fixed burst of N beats keeps `burst_act` high for exactly N cycles. After that, `burst_act` is 0 and `col_out` holds the last beat.
- R6: Length code 3'b111 selects a full-page burst. Beat k is (s + k) mod 2^COL_W, whatever the value of `ilv_mode`. The burst continues past the top of the column range without ending.
- R7: A `cmd_stop` during a full-page burst sets `burst_act` to 0 at that edge. `col_out` then holds the last address.
- R8: `cmd_stop` has no effect during a fixed-length burst. The burst runs to its normal end.
- R9: A `cmd_new` during a burst discards the remaining beats and starts a full-length burst from the new column. `cmd_new` takes priority over `cmd_stop` and `cmd_term` at the same edge. A `cmd_new` on every cycle yields each presented column in turn.
- R10: `cmd_term` ends a burst of any length at that edge. `col_out` then holds the last address.
- R11: While idle, `cmd_stop` and `cmd_term` are ignored: `burst_act` stays 0 and `col_out` is unchanged.
- R12: Changes on `len_code` or `ilv_mode` during a burst do not alter its length or order.
- R13: The unused length codes 3'b100, 3'b101 and 3'b110 behave as a single-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_new | input | 1 | Read or write command that starts a burst |
| cmd_stop | input | 1 | Burst stop strobe (acts on full-page bursts only) |
| cmd_term | input | 1 | Terminate strobe that ends any running burst |
| start_col | input | COL_W | Start column presented with `cmd_new` |
| len_code | input | 3 | Burst length code |
| ilv_mode | input | 1 | 1 = interleaved order, 0 = sequential order |
| col_out | output | COL_W | Column address of the current beat |
| burst_act | output | 1 | High while a burst is producing addresses |

## Verification
The bench sweeps every start column of a 6-bit column space for every fixed length and both orders. A wrap taken on the wrong number of bits, or a misplaced XOR, would show up as a wrong beat at some start offset. Bursts one beat too long or too short are caught by the check on the cycle after the last beat.

Full-page runs cross the top of the column range. This exposes a counter that saturates, or one that wraps inside a small block, and also any leak of the interleave bit into full-page order. Further tests cover:
- interrupts mid-burst, which catch a design that keeps the old count;
- stops during fixed bursts, which catch a design that ends them early;
- idle strobes, which catch a design that restarts or moves the column;
- mode changes mid-burst, which catch a design that reads live mode inputs instead of the captured ones.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

   // Burst length encodings
   localparam logic [2:0] LEN_1    = 3'b000;
   localparam logic [2:0] LEN_2    = 3'b001;
   localparam logic [2:0] LEN_4    = 3'b010;
   localparam logic [2:0] LEN_8    = 3'b011;
   localparam logic [2:0] LEN_FULL = 3'b111;

   // Largest fixed burst is 2**MAX_FIXED_LOG beats
   localparam int MAX_FIXED_LOG = 3;

   typedef struct packed {
      logic [2:0] len;
      logic       ilv;
   } burst_mode_t;

endpackage

// File: rtl/colgen_decode.sv
module colgen_decode
   import colgen_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic [2:0]       len_code,
   output logic [COL_W-1:0] wrap_mask,
   output logic             full_page
);

   localparam int FIX_BITS = MAX_FIXED_LOG;

   logic [COL_W-1:0] fixed_mask;

   assign full_page = (len_code == LEN_FULL);

   // Low bits that count within a fixed burst: len_code of them
   genvar gi;
   generate
      for (gi = 0; gi < COL_W; gi++) begin : g_mask
         if (gi < FIX_BITS) begin : g_low
            assign fixed_mask[gi] = ~len_code[2] & (int'(len_code[1:0]) > gi);
         end else begin : g_high
            assign fixed_mask[gi] = 1'b0;
         end
      end
   endgenerate

   assign wrap_mask = full_page ? {COL_W{1'b1}} : fixed_mask;

endmodule

// File: rtl/colgen_order.sv
module colgen_order #(
   parameter int COL_W = 10
) (
   input  logic [COL_W-1:0] base_col,
   input  logic [COL_W-1:0] beat_cnt,
   input  logic [COL_W-1:0] wrap_mask,
   input  logic             ilv_sel,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] seq_sum;
   logic [COL_W-1:0] ilv_val;

   assign seq_sum = base_col + beat_cnt;
   assign ilv_val = base_col ^ beat_cnt;

   // Per bit: counting bits take the ordered value, others keep the base
   genvar gi;
   generate
      for (gi = 0; gi < COL_W; gi++) begin : g_bit
         assign col[gi] = wrap_mask[gi] ? (ilv_sel ? ilv_val[gi] : seq_sum[gi])
                                        : base_col[gi];
      end
   endgenerate

endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
   import colgen_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_new,
   input  logic             cmd_stop,
   input  logic             cmd_term,
   input  logic [COL_W-1:0] start_col,
   input  burst_mode_t      mode_in,
   input  logic [COL_W-1:0] wrap_mask,
   input  logic             full_page,
   output burst_mode_t      mode_q,
   output logic [COL_W-1:0] base_q,
   output logic [COL_W-1:0] cnt_q,
   output logic             act_q,
   output logic             at_last
);

   // Last beat of a fixed burst: the count equals N-1, which is the mask
   assign at_last = (cnt_q == wrap_mask) && !full_page;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         cnt_q  <= '0;
         base_q <= '0;
         mode_q <= '0;
      end else if (cmd_new) begin
         act_q  <= 1'b1;
         cnt_q  <= '0;
         base_q <= start_col;
         mode_q <= mode_in;
      end else if (act_q) begin
         if (cmd_term) begin
            act_q <= 1'b0;
         end else if (cmd_stop && full_page) begin
            act_q <= 1'b0;
         end else if (at_last) begin
            act_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import colgen_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_new,
   input  logic             cmd_stop,
   input  logic             cmd_term,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       len_code,
   input  logic             ilv_mode,
   output logic [COL_W-1:0] col_out,
   output logic             burst_act
);

   generate
      if (COL_W < MAX_FIXED_LOG + 1) begin : g_bad_width
         $error("burst_col_gen: COL_W must exceed the largest fixed burst width");
      end
   endgenerate

   burst_mode_t      mode_in;
   burst_mode_t      mode_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] cnt_q;
   logic [COL_W-1:0] wrap_mask;
   logic             full_page;
   logic             at_last;
   logic             ilv_eff;

   assign mode_in.len = len_code;
   assign mode_in.ilv = ilv_mode;

   colgen_decode #(.COL_W(COL_W)) u_decode (
      .len_code  (mode_q.len),
      .wrap_mask (wrap_mask),
      .full_page (full_page)
   );

   colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_new   (cmd_new),
      .cmd_stop  (cmd_stop),
      .cmd_term  (cmd_term),
      .start_col (start_col),
      .mode_in   (mode_in),
      .wrap_mask (wrap_mask),
      .full_page (full_page),
      .mode_q    (mode_q),
      .base_q    (base_q),
      .cnt_q     (cnt_q),
      .act_q     (burst_act),
      .at_last   (at_last)
   );

   // Full-page bursts always count sequentially
   assign ilv_eff = mode_q.ilv & ~full_page;

   colgen_order #(.COL_W(COL_W)) u_order (
      .base_col  (base_q),
      .beat_cnt  (cnt_q),
      .wrap_mask (wrap_mask),
      .ilv_sel   (ilv_eff),
      .col       (col_out)
   );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_new,
   input logic             cmd_stop,
   input logic             cmd_term,
   input logic [COL_W-1:0] start_col,
   input logic [COL_W-1:0] col_out,
   input logic             burst_act,
   input logic             full_page,
   input logic             ilv_q,
   input logic [COL_W-1:0] wrap_mask,
   input logic             at_last
);

   // R2
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_new |=> (burst_act && col_out == $past(start_col)));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_act && !cmd_new) |=> (!burst_act && $stable(col_out)));

   // R7
   stop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_act && full_page && cmd_stop && !cmd_new) |=> !burst_act);

   // R8
   stop_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_act && !full_page && !at_last && cmd_stop && !cmd_term && !cmd_new)
      |=> burst_act);

   // R10
   term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_act && cmd_term && !cmd_new) |=> (!burst_act && $stable(col_out)));

   // R3
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_act && !at_last && !cmd_new && !cmd_term && !(cmd_stop && full_page)
       && (!ilv_q || full_page))
      |=> ((((col_out - $past(col_out)) & $past(wrap_mask)) == COL_W'(1))
           && ((col_out & ~$past(wrap_mask)) == ($past(col_out) & ~$past(wrap_mask)))));

   // R5
   end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_act && at_last && !cmd_new) |=> (!burst_act && $stable(col_out)));

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_new   (cmd_new),
   .cmd_stop  (cmd_stop),
   .cmd_term  (cmd_term),
   .start_col (start_col),
   .col_out   (col_out),
   .burst_act (burst_act),
   .full_page (full_page),
   .ilv_q     (mode_q.ilv),
   .wrap_mask (wrap_mask),
   .at_last   (at_last)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

   localparam int CW   = 6;
   localparam int NCOL = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_new = 1'b0;
   logic          cmd_stop = 1'b0;
   logic          cmd_term = 1'b0;
   logic [CW-1:0] start_col = '0;
   logic [2:0]    len_code = 3'b000;
   logic          ilv_mode = 1'b0;
   logic [CW-1:0] col_out;
   logic          burst_act;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   burst_col_gen #(.COL_W(CW)) u_burst_col_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_new   (cmd_new),
      .cmd_stop  (cmd_stop),
      .cmd_term  (cmd_term),
      .start_col (start_col),
      .len_code  (len_code),
      .ilv_mode  (ilv_mode),
      .col_out   (col_out),
      .burst_act (burst_act)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int beats(input int code);
      if (code == 7) return NCOL;
      if (code <= 3) return 1 << code;
      return 1;
   endfunction

   function automatic int exp_col(input int s, input int code, input bit ilv, input int k);
      int m;
      m = (code == 7) ? NCOL - 1 : beats(code) - 1;
      if (ilv && code != 7) return (s & ~m) | ((s ^ k) & m);
      return ((s & ~m) | ((s + k) & m)) % NCOL;
   endfunction

   // Presents a command; returns at the negedge after it was taken
   task automatic issue(input int s, input int code, input bit ilv);
      @(negedge clk);
      cmd_new   = 1'b1;
      start_col = CW'(s);
      len_code  = 3'(code);
      ilv_mode  = ilv;
      @(negedge clk);
      cmd_new   = 1'b0;
   endtask

   // Checks all beats of a fixed burst, then the idle cycle after it
   task automatic expect_burst(input int s, input int code, input bit ilv, input string req);
      int n;
      n = beats(code);
      for (int k = 0; k < n; k++) begin
         chk(col_out == CW'(exp_col(s, code, ilv, k)), req, col_out, exp_col(s, code, ilv, k));
         chk(burst_act == 1'b1, {req, " active"}, burst_act, 1);
         @(negedge clk);
      end
      chk(burst_act == 1'b0, "R5 end", burst_act, 0);
      chk(col_out == CW'(exp_col(s, code, ilv, n - 1)), "R5 hold", col_out, exp_col(s, code, ilv, n - 1));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int held;
      repeat (3) @(negedge clk);
      // R1
      chk(burst_act == 1'b0, "R1 act", burst_act, 0);
      chk(col_out == '0, "R1 col", col_out, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R4 R5: full sweep of fixed bursts
      for (int code = 0; code < 4; code++)
         for (int ilv = 0; ilv < 2; ilv++)
            for (int s = 0; s < NCOL; s++) begin
               issue(s, code, ilv[0]);
               expect_burst(s, code, ilv[0], ilv != 0 ? "R4" : "R3");
            end

      // R13: unused codes give one beat
      for (int code = 4; code < 7; code++) begin
         issue(13 + code, code, 1'b0);
         expect_burst(13 + code, code, 1'b0, "R13");
      end

      // R6 R7: full page across the top, interleave bit ignored, then stop
      issue(60, 7, 1'b1);
      for (int k = 0; k < 70; k++) begin
         chk(col_out == CW'((60 + k) % NCOL), "R6", col_out, (60 + k) % NCOL);
         chk(burst_act == 1'b1, "R6 active", burst_act, 1);
         if (k == 69) cmd_stop = 1'b1;
         @(negedge clk);
      end
      cmd_stop = 1'b0;
      chk(burst_act == 1'b0, "R7 stop", burst_act, 0);
      chk(col_out == CW'((60 + 69) % NCOL), "R7 hold", col_out, (60 + 69) % NCOL);

      // R8: stop during a fixed burst is ignored
      issue(22, 2, 1'b0);
      for (int k = 0; k < 4; k++) begin
         chk(col_out == CW'(exp_col(22, 2, 1'b0, k)), "R8", col_out, exp_col(22, 2, 1'b0, k));
         chk(burst_act == 1'b1, "R8 active", burst_act, 1);
         cmd_stop = (k == 1);
         @(negedge clk);
      end
      cmd_stop = 1'b0;
      chk(burst_act == 1'b0, "R8 end", burst_act, 0);

      // R10: terminate ends a fixed burst
      issue(10, 3, 1'b0);
      for (int k = 0; k < 3; k++) begin
         chk(col_out == CW'(exp_col(10, 3, 1'b0, k)), "R10", col_out, exp_col(10, 3, 1'b0, k));
         cmd_term = (k == 2);
         @(negedge clk);
      end
      cmd_term = 1'b0;
      chk(burst_act == 1'b0, "R10 end", burst_act, 0);
      chk(col_out == CW'(exp_col(10, 3, 1'b0, 2)), "R10 hold", col_out, exp_col(10, 3, 1'b0, 2));

      // R11: idle strobes ignored
      held = col_out;
      cmd_stop = 1'b1;
      @(negedge clk);
      cmd_stop = 1'b0;
      cmd_term = 1'b1;
      @(negedge clk);
      cmd_term = 1'b0;
      @(negedge clk);
      chk(burst_act == 1'b0, "R11 act", burst_act, 0);
      chk(col_out == CW'(held), "R11 col", col_out, held);

      // R9: interrupt restarts with full length, with stop and term also high
      issue(3, 3, 1'b0);
      for (int k = 0; k < 3; k++) begin
         chk(col_out == CW'(exp_col(3, 3, 1'b0, k)), "R9 first", col_out, exp_col(3, 3, 1'b0, k));
         @(negedge clk);
      end
      cmd_new = 1'b1; cmd_stop = 1'b1; cmd_term = 1'b1;
      start_col = CW'(40); len_code = 3'd3; ilv_mode = 1'b1;
      @(negedge clk);
      cmd_new = 1'b0; cmd_stop = 1'b0; cmd_term = 1'b0;
      expect_burst(40, 3, 1'b1, "R9");

      // R9: random column access, a command every cycle
      @(negedge clk);
      for (int j = 0; j < 8; j++) begin
         cmd_new = 1'b1;
         start_col = CW'((j * 23 + 5) % NCOL);
         len_code = 3'd2;
         @(negedge clk);
         chk(col_out == CW'((j * 23 + 5) % NCOL), "R9 random", col_out, (j * 23 + 5) % NCOL);
         chk(burst_act == 1'b1, "R9 random active", burst_act, 1);
      end
      cmd_new = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);

      // R12: mode inputs change during a burst
      issue(5, 3, 1'b0);
      len_code = 3'd0;
      ilv_mode = 1'b1;
      expect_burst(5, 3, 1'b0, "R12");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule